// File: doc/BRIEF.md
# Timer Status Flag Register

This block is the 8-bit status register of one channel of a 16-bit up/down timer. The counter core sends it single-cycle strobes: a compare match and a capture for each of the two general registers A and B, a wrap upward past the top, a wrap downward past zero, and the current count direction. The block turns these strobes into sticky flags. Software reads the flags over a simple bus port, and an interrupt request goes out for each flag that is set and enabled.

A flag never clears by accident. Software must first read the register while the flag is 1, and then write 0 to that bit. A read that sees the flag as 1 arms the flag, and any write disarms every flag. The two compare/capture flags also clear when the DMA controller services their interrupt, unless that transfer asks to keep the flag. A hardware set in the same cycle as any clear wins, so no event is lost.

Top module: `tsr_top`

## Requirements
- R1: After reset the register reads 0xC0: bit 7 (direction) and bit 6 are 1, all other bits 0, and every interrupt request is 0.
- R2: Bit 0 (flag A) sets on `cmp_a` when `capmode_a` is 0 and on `cap_a` when `capmode_a` is 1. The strobe of the other mode is ignored. Bit 1 (flag B) does the same with `cmp_b`, `cap_b` and `capmode_b`.
- R3: Bit 4 sets on `wrap_up` (0xFFFF to 0x0000). Bit 5 sets on `wrap_down` (0x0000 to 0xFFFF).
- R4: Bit 7 reads the value `count_up` had at the previous clock edge: 1 while counting up, 0 while counting down. Writes do not change it.
- R5: Bit 6 always reads 1 and bits 3 and 2 always read 0, whatever is written.
- R6: Writing 1 to bits 5, 4, 1 or 0 has no effect on those flags.
- R7: Writing 0 to a set flag that has not been read as 1 since the last write leaves the flag set.
- R8: A read (`bus_rd`=1) that returns a flag as 1 arms that flag. The next write with 0 in that bit clears it. Any write disarms all flags.
- R9: A `dma_svc_a` (or `dma_svc_b`) strobe with `dma_keep_a` (or `dma_keep_b`) at 0 clears flag A (or B) and disarms it. With the keep input at 1 the flag stays set. The DMA strobes never affect bits 4 and 5.
- R10: A set strobe in the same cycle as a write clear or a DMA clear leaves the flag at 1.
- R11: `irq_req[i]` is 1 exactly while flag i is set and `irq_en[i]` is 1. Index order is A, B, overflow, underflow. The request drops in the cycle after the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe; arms flags that read as 1 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register contents |
| cmp_a | input | 1 | Compare match on register A |
| cap_a | input | 1 | Capture into register A |
| capmode_a | input | 1 | Register A is in capture mode |
| cmp_b | input | 1 | Compare match on register B |
| cap_b | input | 1 | Capture into register B |
| capmode_b | input | 1 | Register B is in capture mode |
| wrap_up | input | 1 | Counter wrapped 0xFFFF to 0x0000 |
| wrap_down | input | 1 | Counter wrapped 0x0000 to 0xFFFF |
| count_up | input | 1 | Current count direction, 1 = up |
| dma_svc_a | input | 1 | DMA controller serviced the flag A request |
| dma_keep_a | input | 1 | That transfer keeps flag A set |
| dma_svc_b | input | 1 | DMA controller serviced the flag B request |
| dma_keep_b | input | 1 | That transfer keeps flag B set |
| irq_en | input | 4 | Interrupt enables (A, B, overflow, underflow) |
| irq_req | output | 4 | Interrupt requests (A, B, overflow, underflow) |

## Verification
The assertions assume every event input is a strobe sampled at one clock edge. They also assume that a read and a write never occur in the same cycle, and that the keep inputs are valid whenever their service strobe is high. The bench drives all inputs on the falling edge and holds each strobe for exactly one cycle. It keeps `bus_rd` and `bus_wr` apart, except in one scenario that overlaps a write clear with a set strobe on purpose. It observes flags through `bus_rdata` with `bus_rd` low, so these observations never arm anything.

// File: rtl/tsr_pkg.sv
// Shared constants for the timer status register.
// Assumes: clearable flags are indexed A, B, overflow, underflow.
package tsr_pkg;
    localparam int REG_W   = 8;
    localparam int N_FLAGS = 4;
    localparam int N_DMA   = 2;
    localparam int POS_DIR = 7;
    localparam int POS_ONE = 6;
    localparam logic [REG_W-1:0] FIXED_ONES = 8'h40;

    typedef enum logic [1:0] {
        FL_A   = 2'd0,
        FL_B   = 2'd1,
        FL_OVF = 2'd2,
        FL_UNF = 2'd3
    } flag_idx_e;

    // Bit position of clearable flag i in the register
    function automatic int flag_pos(input int i);
        case (i)
            0:       return 0;
            1:       return 1;
            2:       return 4;
            default: return 5;
        endcase
    endfunction
endpackage

// File: rtl/tsr_event_map.sv
// Maps counter-core strobes to per-flag set requests and DMA clear requests.
// Assumes: strobes are single-cycle; only flags below N_DMA have a DMA path.
module tsr_event_map
    import tsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_DMA-1:0]   cmp_i,
    input  logic [N_DMA-1:0]   cap_i,
    input  logic [N_DMA-1:0]   capmode_i,
    input  logic               wrap_up_i,
    input  logic               wrap_down_i,
    input  logic [N_DMA-1:0]   dma_svc_i,
    input  logic [N_DMA-1:0]   dma_keep_i,
    output logic [N_FLAGS-1:0] set_o,
    output logic [N_FLAGS-1:0] dma_clr_o
);
    for (genvar g = 0; g < N_FLAGS; g++) begin : g_map
        if (g < N_DMA) begin : g_cc
            // Select the strobe that belongs to the register's current mode
            always_comb set_o[g] = capmode_i[g] ? cap_i[g] : cmp_i[g];
            // DMA service clears unless the transfer keeps the flag
            always_comb dma_clr_o[g] = dma_svc_i[g] & ~dma_keep_i[g];

            // R2
            mode_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (capmode_i[g] && !cap_i[g]) |-> !set_o[g]);
            // R9
            dma_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                dma_keep_i[g] |-> !dma_clr_o[g]);
        end else if (g == int'(FL_OVF)) begin : g_ovf
            // Overflow wrap sets the overflow flag; no DMA path
            always_comb set_o[g] = wrap_up_i;
            always_comb dma_clr_o[g] = 1'b0;
        end else begin : g_unf
            // Underflow wrap sets the underflow flag; no DMA path
            always_comb set_o[g] = wrap_down_i;
            always_comb dma_clr_o[g] = 1'b0;
        end
    end
endmodule

// File: rtl/tsr_flag_cell.sv
// One sticky status flag with its read-as-1 arm bit.
// Assumes: read and write strobes are not active in the same cycle;
// a set request overrides any clear in the same cycle.
module tsr_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    input  logic dma_clr_i,
    output logic flag_o
);
    logic flag_q;
    logic arm_q;
    logic wr_clr;

    // A write of 0 clears only an armed flag
    always_comb wr_clr = wr_i & ~wbit_i & arm_q;

    // Flag register: set wins over either clear path
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else
            flag_q <= set_i | (flag_q & ~(wr_clr | dma_clr_i));
    end

    // Arm register: armed by a read of 1, dropped by any write or DMA clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            arm_q <= 1'b0;
        else if (wr_i || dma_clr_i)
            arm_q <= 1'b0;
        else if (rd_i && flag_q)
            arm_q <= 1'b1;
    end

    assign flag_o = flag_q;

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);
    // R7
    unarmed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && wr_i && !arm_q && !dma_clr_i) |=> flag_q);
    // R6
    write_one_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && wr_i && wbit_i && !dma_clr_i) |=> flag_q);
    // R8
    armed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wbit_i && arm_q && !set_i) |=> !flag_q);
    // R8
    write_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> !arm_q);
    // R9
    dma_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_clr_i && !set_i) |=> (!flag_q && !arm_q));
endmodule

// File: rtl/tsr_top.sv
// Status register of one up/down timer channel: sticky event flags with
// guarded clearing, DMA clearing of compare/capture flags, direction bit
// and per-flag interrupt requests.
// Assumes: event inputs are single-cycle strobes from the counter core.
module tsr_top
    import tsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic               cmp_a,
    input  logic               cap_a,
    input  logic               capmode_a,
    input  logic               cmp_b,
    input  logic               cap_b,
    input  logic               capmode_b,
    input  logic               wrap_up,
    input  logic               wrap_down,
    input  logic               count_up,
    input  logic               dma_svc_a,
    input  logic               dma_keep_a,
    input  logic               dma_svc_b,
    input  logic               dma_keep_b,
    input  logic [N_FLAGS-1:0] irq_en,
    output logic [N_FLAGS-1:0] irq_req
);
    logic [N_FLAGS-1:0] set_vec;
    logic [N_FLAGS-1:0] dma_clr_vec;
    logic [N_FLAGS-1:0] flags;
    logic               dir_q;

    tsr_event_map u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_i      ({cmp_b, cmp_a}),
        .cap_i      ({cap_b, cap_a}),
        .capmode_i  ({capmode_b, capmode_a}),
        .wrap_up_i  (wrap_up),
        .wrap_down_i(wrap_down),
        .dma_svc_i  ({dma_svc_b, dma_svc_a}),
        .dma_keep_i ({dma_keep_b, dma_keep_a}),
        .set_o      (set_vec),
        .dma_clr_o  (dma_clr_vec)
    );

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        tsr_flag_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (set_vec[g]),
            .rd_i     (bus_rd),
            .wr_i     (bus_wr),
            .wbit_i   (bus_wdata[flag_pos(g)]),
            .dma_clr_i(dma_clr_vec[g]),
            .flag_o   (flags[g])
        );
        // Request is the flag gated by its enable
        always_comb irq_req[g] = flags[g] & irq_en[g];
    end

    // Direction bit: registered copy of the counter direction, up at reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= 1'b1;
        else
            dir_q <= count_up;
    end

    // Assemble read data from fixed bits, direction and flags
    always_comb begin
        bus_rdata          = FIXED_ONES;
        bus_rdata[POS_DIR] = dir_q;
        for (int i = 0; i < N_FLAGS; i++)
            bus_rdata[flag_pos(i)] = flags[i];
    end

    // R5
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[POS_ONE] && bus_rdata[3:2] == 2'b00));
    // R4
    dir_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bus_rdata[POS_DIR] == $past(count_up)));
    // R3
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_up |=> bus_rdata[flag_pos(int'(FL_OVF))]);
    // R11
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[int'(FL_A)]) |-> !irq_req[int'(FL_A)]);
endmodule

// File: tb/test_tsr_top.sv
module test_tsr_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_rd, bus_wr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       cmp_a, cap_a, capmode_a, cmp_b, cap_b, capmode_b;
    logic       wrap_up, wrap_down, count_up;
    logic       dma_svc_a, dma_keep_a, dma_svc_b, dma_keep_b;
    logic [3:0] irq_en, irq_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    tsr_top i_tsr_top (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_read();
        bus_rd = 1'b1; tick(); bus_rd = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] v);
        bus_wr = 1'b1; bus_wdata = v; tick(); bus_wr = 1'b0;
    endtask

    task automatic set_all();
        capmode_a = 0; capmode_b = 0;
        cmp_a = 1; cmp_b = 1; wrap_up = 1; wrap_down = 1; tick();
        cmp_a = 0; cmp_b = 0; wrap_up = 0; wrap_down = 0;
    endtask

    task automatic clear_all();
        do_read(); do_write(8'h00);
    endtask

    task automatic t_reset();
        check("R1 reset value", bus_rdata, 8'hC0);
        check("R1 reset irq", {4'h0, irq_req}, 8'h00);
    endtask

    task automatic t_sources();
        capmode_a = 0; cmp_a = 1; tick(); cmp_a = 0;
        check("R2 compare sets A", bus_rdata & 8'h33, 8'h01);
        clear_all();
        capmode_a = 1; cmp_a = 1; tick(); cmp_a = 0;
        check("R2 compare ignored in capture mode", bus_rdata & 8'h33, 8'h00);
        cap_a = 1; tick(); cap_a = 0;
        check("R2 capture sets A", bus_rdata & 8'h33, 8'h01);
        clear_all();
        capmode_b = 0; cap_b = 1; tick(); cap_b = 0;
        check("R2 capture ignored in compare mode", bus_rdata & 8'h33, 8'h00);
        cmp_b = 1; tick(); cmp_b = 0;
        check("R2 compare sets B", bus_rdata & 8'h33, 8'h02);
        clear_all();
        capmode_a = 0;
        wrap_up = 1; tick(); wrap_up = 0;
        check("R3 overflow", bus_rdata & 8'h33, 8'h10);
        clear_all();
        wrap_down = 1; tick(); wrap_down = 0;
        check("R3 underflow", bus_rdata & 8'h33, 8'h20);
        clear_all();
    endtask

    task automatic t_direction();
        count_up = 0; tick();
        check("R4 counting down", bus_rdata, 8'h40);
        do_write(8'hFF);
        check("R4 direction read-only", bus_rdata, 8'h40);
        count_up = 1; tick();
        check("R4 counting up", bus_rdata, 8'hC0);
    endtask

    task automatic t_reserved();
        do_write(8'h0C);
        check("R5 reserved ones", bus_rdata & 8'h4C, 8'h40);
        do_write(8'h00);
        check("R5 reserved zeros", bus_rdata & 8'h4C, 8'h40);
    endtask

    task automatic t_write_one();
        set_all();
        do_read();
        do_write(8'hFF);
        check("R6 write 1 keeps flags", bus_rdata, 8'hF3);
        do_write(8'h00);
        check("R8 write disarms all flags", bus_rdata, 8'hF3);
        clear_all();
        check("R8 read then write 0 clears all", bus_rdata, 8'hC0);
    endtask

    task automatic t_unarmed();
        cmp_a = 1; tick(); cmp_a = 0;
        do_write(8'h00);
        check("R7 write 0 without read", bus_rdata, 8'hC1);
        clear_all();
    endtask

    task automatic t_selective();
        set_all();
        do_read();
        do_write(8'hFE);
        check("R8 clear only A", bus_rdata, 8'hF2);
        clear_all();
    endtask

    task automatic t_dma();
        set_all();
        dma_svc_a = 1; dma_keep_a = 1; tick(); dma_svc_a = 0; dma_keep_a = 0;
        check("R9 keep bit blocks DMA clear", bus_rdata, 8'hF3);
        dma_svc_a = 1; tick(); dma_svc_a = 0;
        check("R9 DMA clears A", bus_rdata, 8'hF2);
        dma_svc_b = 1; tick(); dma_svc_b = 0;
        check("R9 DMA clears B, wraps untouched", bus_rdata, 8'hF0);
        clear_all();
        cmp_a = 1; tick(); cmp_a = 0;
        do_read();
        dma_svc_a = 1; tick(); dma_svc_a = 0;
        cmp_a = 1; tick(); cmp_a = 0;
        do_write(8'h00);
        check("R9 DMA clear disarms", bus_rdata, 8'hC1);
        clear_all();
    endtask

    task automatic t_set_wins();
        cmp_a = 1; tick(); cmp_a = 0;
        do_read();
        bus_wr = 1; bus_wdata = 8'h00; cmp_a = 1; tick();
        bus_wr = 0; cmp_a = 0;
        check("R10 set beats write clear", bus_rdata, 8'hC1);
        capmode_b = 1; cap_b = 1; tick(); cap_b = 0;
        dma_svc_b = 1; cap_b = 1; tick(); dma_svc_b = 0; cap_b = 0;
        check("R10 set beats DMA clear", bus_rdata, 8'hC3);
        capmode_b = 0;
        clear_all();
    endtask

    task automatic t_irq();
        irq_en = 4'b0101;
        set_all();
        check("R11 irq gated by enable", {4'h0, irq_req}, 8'h05);
        irq_en = 4'b1111; #1;
        check("R11 irq all enabled", {4'h0, irq_req}, 8'h0F);
        do_read();
        do_write(8'hFE);
        check("R11 irq drops after clear", {4'h0, irq_req}, 8'h0E);
        clear_all();
        check("R11 irq all low", {4'h0, irq_req}, 8'h00);
        irq_en = 4'b0000;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 0;
        cmp_a = 0; cap_a = 0; capmode_a = 0; cmp_b = 0; cap_b = 0; capmode_b = 0;
        wrap_up = 0; wrap_down = 0; count_up = 1;
        dma_svc_a = 0; dma_keep_a = 0; dma_svc_b = 0; dma_keep_b = 0; irq_en = 0;
        @(negedge clk); tick(); tick();
        rst_n = 1;
        t_reset();
        t_sources();
        t_direction();
        t_reserved();
        t_write_one();
        t_unarmed();
        t_selective();
        t_dma();
        t_set_wins();
        t_irq();
        finish_run();
    end
endmodule